// File: doc/BRIEF.md
# Return Address Stack Predictor

This block guesses where a procedure return will jump. It sits beside an instruction prefetch unit and keeps the most recent return addresses in a small ring of slots addressed by one top-of-stack pointer. The decode logic signals each taken procedure call together with the address that follows the call. The block writes that address into the ring. The decode logic also signals each taken procedure return. When it does, the block offers the newest stored address as a fetch target in the same cycle and then discards it. Upstream logic decides what counts as a call or a return. A conditional return is signalled only when the direction predictor has marked it taken. An unconditional return is always signalled. A plain copy of the link register into the program counter is never signalled as a return. The execute stage checks every predicted target. A wrong guess costs only a flush and a refetch, so the output is a hint and carries no handshake.

The ring has no overflow or underflow detection. A push onto a full ring overwrites the oldest entry. A pop from an empty ring moves the pointer back around to the last slot. A disable input stops all writes and removes the prediction. The `FREEZE_OFF` parameter selects how the pointer behaves while the block is disabled: it either keeps following calls and returns, or it stays where it is. A flush input marks the strobes in that cycle as belonging to squashed instructions, and the block ignores them. The input strobes are one-cycle pulses and have no ready signal. The block accepts one call and one return in every cycle and never applies back-pressure.

Top module: `ras_predictor`

## Requirements
- R1: Reset sets the pointer to slot 0 and clears every slot to zero, so a return issued just after reset predicts address 0.
- R2: A call pushes its address and a return predicts the most recently pushed address that is still live, in last-in first-out order.
- R3: The slot count `DEPTH` (default 4, a power of two) sets the capacity. With the default, five pushes A..E followed by five returns predict E, D, C, B, E, because E overwrote A.
- R4: A return on an empty ring reads the last slot (index `DEPTH`-1) and moves the pointer back around to it. The next push then writes that slot.
- R5: `pred_vld_o` is high in the same cycle as `ret_taken_i`, and only when the block is enabled and not flushed. `pred_target_o` shows the top entry in that cycle, and the pop takes effect at the following clock edge.
- R6: A call and a return in the same cycle predict the old top entry, replace it with the call address, and leave the pointer where it was.
- R7: While `stack_off_i` is high, a call writes no slot.
- R8: While `stack_off_i` is high and `FREEZE_OFF`=0, the pointer still moves up on calls and down on returns. When `FREEZE_OFF`=1, it stays fixed.
- R9: While `flush_i` is high, call and return strobes in that cycle change neither the slots nor the pointer, and `pred_vld_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| call_taken_i | input | 1 | Taken procedure call seen this cycle |
| call_ret_addr_i | input | AW | Return address that goes with the call |
| ret_taken_i | input | 1 | Taken procedure return seen this cycle |
| stack_off_i | input | 1 | Disables the predictor |
| flush_i | input | 1 | Strobes this cycle belong to squashed instructions |
| pred_vld_o | output | 1 | Predicted target is offered |
| pred_target_o | output | AW | Predicted return target (top entry) |

## Verification
A push and a pop can land in the same cycle. This is the one place where the read of the top entry and the write into the ring must be ordered. The bench provokes it by raising both strobes together over a stack two entries deep. The prediction in that cycle must be the old top. The next two returns must give the new call address and then the entry below it, which shows that the pointer did not move. Two instances run on the same stimulus, one with each `FREEZE_OFF` setting, so the disabled-pointer behaviour is judged by their differing predictions.

// File: rtl/ras_pkg.sv
package ras_pkg;
  // Qualified per-cycle actions derived from the input strobes
  typedef struct packed {
    logic push;   // call accepted (not flushed)
    logic pop;    // return accepted (not flushed)
    logic write;  // slot write permitted (push and enabled)
  } ras_ctl_t;
endpackage

// File: rtl/ras_ptr.sv
module ras_ptr
  import ras_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter bit FREEZE_OFF = 1'b0,
  localparam int PW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ras_ctl_t      ctl_i,
  input  logic          off_i,
  output logic [PW-1:0] tos_o,
  output logic [PW-1:0] top_o
);
  logic [PW-1:0] tos_q;
  logic          hold;

  generate
    if (FREEZE_OFF) begin : g_freeze
      assign hold = off_i;
    end else begin : g_track
      assign hold = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tos_q <= '0;
    end else if (!hold) begin
      unique case ({ctl_i.push, ctl_i.pop})
        2'b10:   tos_q <= tos_q + 1'b1;
        2'b01:   tos_q <= tos_q - 1'b1;
        default: tos_q <= tos_q;
      endcase
    end
  end

  assign tos_o = tos_q;
  assign top_o = tos_q - 1'b1;

  // R3: pointer moves by at most one slot per cycle, wrapping modulo DEPTH
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((tos_q - $past(tos_q)) == PW'(0)) ||
             ((tos_q - $past(tos_q)) == PW'(1)) ||
             ((tos_q - $past(tos_q)) == {PW{1'b1}}));

  generate
    if (FREEZE_OFF) begin : g_frz_chk
      // R8: frozen variant keeps the pointer still while disabled
      a_r8_frozen_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        off_i |=> $stable(tos_q));
    end
  endgenerate
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [PW-1:0] waddr_i,
  input  logic [AW-1:0] wdata_i,
  input  logic [PW-1:0] raddr_i,
  output logic [AW-1:0] rdata_o
);
  logic [DEPTH-1:0][AW-1:0] slots;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          slots[i] <= '0;
        end else if (we_i && (waddr_i == PW'(i))) begin
          slots[i] <= wdata_i;
        end
      end
    end
  endgenerate

  assign rdata_o = slots[raddr_i];

  // R7: without a write enable no slot changes
  a_r7_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(slots));
endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
  import ras_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int AW         = 32,
  parameter bit FREEZE_OFF = 1'b0,
  localparam int PW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_taken_i,
  input  logic [AW-1:0] call_ret_addr_i,
  input  logic          ret_taken_i,
  input  logic          stack_off_i,
  input  logic          flush_i,
  output logic          pred_vld_o,
  output logic [AW-1:0] pred_target_o
);
  ras_ctl_t      ctl;
  logic [PW-1:0] tos;
  logic [PW-1:0] top;
  logic [PW-1:0] waddr;

  always_comb begin
    ctl.push  = call_taken_i && !flush_i;
    ctl.pop   = ret_taken_i  && !flush_i;
    ctl.write = ctl.push && !stack_off_i;
  end

  // A simultaneous pop vacates the top slot; the push reuses it
  assign waddr = ctl.pop ? top : tos;

  ras_ptr #(.DEPTH(DEPTH), .FREEZE_OFF(FREEZE_OFF)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl_i (ctl),
    .off_i (stack_off_i),
    .tos_o (tos),
    .top_o (top)
  );

  ras_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (ctl.write),
    .waddr_i (waddr),
    .wdata_i (call_ret_addr_i),
    .raddr_i (top),
    .rdata_o (pred_target_o)
  );

  assign pred_vld_o = ctl.pop && !stack_off_i;

  // R2: after a lone enabled push the new top is the pushed address
  a_r2_push_on_top: assert property (@(posedge clk) disable iff (!rst_n)
    (call_taken_i && !ret_taken_i && !flush_i && !stack_off_i)
      |=> pred_target_o == $past(call_ret_addr_i));

  // R6: call+return pair replaces the top entry in place
  a_r6_pair_replaces_top: assert property (@(posedge clk) disable iff (!rst_n)
    (call_taken_i && ret_taken_i && !flush_i && !stack_off_i)
      |=> (pred_target_o == $past(call_ret_addr_i)) && $stable(tos));

  // R9: a flushed cycle leaves the pointer and the top entry untouched
  a_r9_flush_inert: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> $stable(tos) && $stable(pred_target_o));

  // R5: no prediction is offered while disabled
  a_r5_off_no_pred: assert property (@(posedge clk) disable iff (!rst_n)
    stack_off_i |-> !pred_vld_o);
endmodule

// File: tb/ras_predictor_tb.sv
module ras_predictor_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          call_taken, ret_taken, stack_off, flush;
  logic [AW-1:0] call_addr;
  logic          vld_m, vld_f;
  logic [AW-1:0] tgt_m, tgt_f;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  ras_predictor #(.DEPTH(4), .AW(AW), .FREEZE_OFF(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .call_taken_i(call_taken), .call_ret_addr_i(call_addr),
    .ret_taken_i(ret_taken), .stack_off_i(stack_off), .flush_i(flush),
    .pred_vld_o(vld_m), .pred_target_o(tgt_m));

  ras_predictor #(.DEPTH(4), .AW(AW), .FREEZE_OFF(1'b1)) u_frz (
    .clk(clk), .rst_n(rst_n), .call_taken_i(call_taken), .call_ret_addr_i(call_addr),
    .ret_taken_i(ret_taken), .stack_off_i(stack_off), .flush_i(flush),
    .pred_vld_o(vld_f), .pred_target_o(tgt_f));

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; call_taken = 0; ret_taken = 0; stack_off = 0; flush = 0; call_addr = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One cycle of stimulus; outputs sampled 1 ns after driving, before the edge
  task automatic step(input logic c, input logic r, input logic [AW-1:0] a,
                      input logic off, input logic fl);
    @(negedge clk);
    call_taken = c; ret_taken = r; call_addr = a; stack_off = off; flush = fl;
    #1;
  endtask

  task automatic idle();
    step(0, 0, '0, 0, 0);
  endtask

  task automatic push(input logic [AW-1:0] a);
    step(1, 0, a, 0, 0);
  endtask

  // Return on both instances, checking prediction of each
  task automatic pop_chk(input string tag, input logic [AW-1:0] em, input logic [AW-1:0] ef);
    step(0, 1, '0, 0, 0);
    chk({tag, " vld"}, AW'(vld_m), AW'(1));
    chk({tag, " track"}, tgt_m, em);
    chk({tag, " freeze"}, tgt_f, ef);
  endtask

  task automatic t_reset();  // R1
    do_reset();
    idle();
    chk("R1 idle vld", AW'(vld_m), AW'(0));
    pop_chk("R1 reset slot", 32'h0, 32'h0);
  endtask

  task automatic t_lifo();  // R2
    do_reset();
    push(32'h1000); push(32'h2000); push(32'h3000);
    pop_chk("R2 first", 32'h3000, 32'h3000);
    pop_chk("R2 second", 32'h2000, 32'h2000);
    pop_chk("R2 third", 32'h1000, 32'h1000);
  endtask

  task automatic t_overflow();  // R3
    do_reset();
    for (int i = 0; i < 5; i++) push(32'hA0 + i);
    pop_chk("R3 pop E", 32'hA4, 32'hA4);
    pop_chk("R3 pop D", 32'hA3, 32'hA3);
    pop_chk("R3 pop C", 32'hA2, 32'hA2);
    pop_chk("R3 pop B", 32'hA1, 32'hA1);
    pop_chk("R3 wrap E", 32'hA4, 32'hA4);
  endtask

  task automatic t_underflow();  // R4
    do_reset();
    push(32'h55);
    pop_chk("R4 live", 32'h55, 32'h55);
    pop_chk("R4 empty", 32'h0, 32'h0);
    push(32'h77);
    pop_chk("R4 last slot", 32'h77, 32'h77);
  endtask

  task automatic t_timing();  // R5
    do_reset();
    push(32'hBEEF);
    step(0, 1, '0, 1, 0);
    chk("R5 off vld", AW'(vld_m), AW'(0));
    chk("R5 off vld frz", AW'(vld_f), AW'(0));
    do_reset();
    push(32'hBEEF);
    step(0, 1, '0, 0, 0);
    chk("R5 same-cycle vld", AW'(vld_m), AW'(1));
    chk("R5 same-cycle tgt", tgt_m, 32'hBEEF);
    idle();
    chk("R5 vld drops", AW'(vld_m), AW'(0));
  endtask

  task automatic t_pair();  // R6
    do_reset();
    push(32'h10); push(32'h20);
    step(1, 1, 32'h30, 0, 0);
    chk("R6 pair old top", tgt_m, 32'h20);
    chk("R6 pair vld", AW'(vld_m), AW'(1));
    pop_chk("R6 new top", 32'h30, 32'h30);
    pop_chk("R6 below", 32'h10, 32'h10);
  endtask

  task automatic t_disable();  // R7, R8
    do_reset();
    push(32'hA); push(32'hB);
    step(1, 0, 32'hEE, 1, 0);
    pop_chk("R7 R8 after off call", 32'h0, 32'hB);
    pop_chk("R8 next", 32'hB, 32'hA);
    do_reset();
    push(32'hA); push(32'hB); push(32'hC);
    step(0, 1, '0, 0, 0); step(0, 1, '0, 0, 0);
    step(1, 0, 32'hEE, 1, 0);
    pop_chk("R7 stale slot", 32'hB, 32'hA);
    do_reset();
    push(32'hA); push(32'hB);
    step(0, 1, '0, 1, 0);
    pop_chk("R8 off return", 32'hA, 32'hB);
  endtask

  task automatic t_flush();  // R9
    do_reset();
    push(32'h900);
    step(1, 0, 32'h999, 0, 1);
    step(0, 1, '0, 0, 1);
    chk("R9 flush vld", AW'(vld_m), AW'(0));
    pop_chk("R9 intact", 32'h900, 32'h900);
    pop_chk("R9 ptr kept", 32'h0, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; call_taken = 0; ret_taken = 0; stack_off = 0; flush = 0; call_addr = '0;
    t_reset();
    t_lifo();
    t_overflow();
    t_underflow();
    t_timing();
    t_pair();
    t_disable();
    t_flush();
    idle();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule